// File: doc/BRIEF.md
# Sub-Source Sort and Regroup Sequencer

This block builds the switching order of the upper, thermometer-coded segment of a current-steering converter. Each upper-segment unit is built from two half sources that should carry the same current. A sensor outside this block measures the error of each half source and delivers it as a signed number. The block collects one error value per half source. It sorts the values and joins the halves into pairs, so that large positive errors cancel large negative ones. It then writes a table that states, for each thermometer level, which two half sources form the unit that switches at that level.

Values arrive one at a time under a strobe. When the table is complete a ready flag goes high. The thermometer decoder reads the table through a registered lookup port. A table that is being rebuilt stays readable, and it returns the previous contents until the new pairs have been written.

Top module: `subsrc_regroup_seq`

## Requirements
- R1: After synchronous reset, `ready` is low and the block waits for the first error sample.
- R2: An error sample is an 8-bit two's complement value. The i-th sample accepted in a load (i from 0 to 29) belongs to half source i. A load ends after 30 accepted samples.
- R3: The 30 samples are ordered by ascending signed value. Equal values keep the lower half-source index first.
- R4: Pair k (k from 0 to 14) joins the half source at sorted position k with the half source at sorted position 29-k. The first field names the one from the low end and the second field names the one from the high end.
- R5: Pairs are placed in table entries by ascending magnitude of their summed error. Pairs with equal magnitude keep ascending k.
- R6: `seq_sel` = e (0 to 14) selects the entry that serves thermometer level e+1. `seq_sub_a` (low-end index) and `seq_sub_b` (high-end index) show that entry on the clock cycle after `seq_sel` is applied.
- R7: `ready` rises once all 15 entries have been written. The first sample accepted in a new load drops it on the next cycle.
- R8: Until a new table is complete, reads return the entries of the previous table. This holds during a load and during processing.
- R9: Strobes that arrive after the 30th sample and before `ready` rises are ignored.
- R10: `ready` rises no more than 64 clock cycles after the edge that captures the 30th sample.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | Strobe for one error sample |
| meas_value | input | 8 | Signed error of the current half source |
| seq_sel | input | 4 | Table entry to read (thermometer level minus one) |
| seq_sub_a | output | 5 | Low-end half-source index of the selected entry |
| seq_sub_b | output | 5 | High-end half-source index of the selected entry |
| ready | output | 1 | A complete table has been built since the last load began |

## Verification
The assertions rely on three assumptions about the inputs. Samples come in complete sets of 30. A strobe seen outside the loading phase is dropped. `seq_sel` stays below 15. Under these assumptions the internal sorts must yield a non-decreasing order that is a permutation of the indices, and the processing window must stay bounded. The stimulus always sends full sets of 30 and reads only entries 0 to 14. To probe the ignore rule, it holds the strobe high with a junk value for the first 20 cycles of processing. It splits one load in two so that the old table can be read while the new one is still being collected. The patterns cover ramps, all-equal values, full-scale alternation with tied residuals, and scrambled values.

// File: rtl/mm_regroup_pkg.sv
package mm_regroup_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_S1LD,
    ST_S1RUN,
    ST_S2LD,
    ST_S2RUN,
    ST_WR
  } seq_state_t;
endpackage

// File: rtl/mm_oet_sorter.sv
module mm_oet_sorter #(
  parameter int N     = 30,
  parameter int KEY_W = 8,
  parameter int TAG_W = 5,
  localparam int PC_W = $clog2(N + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [N-1:0][KEY_W-1:0]    keys_in,
  input  logic [N-1:0][TAG_W-1:0]    tags_in,
  output logic [N-1:0][KEY_W-1:0]    keys_out,
  output logic [N-1:0][TAG_W-1:0]    tags_out,
  output logic                       done
);
  logic [N-1:0][KEY_W-1:0] k_q, k_n;
  logic [N-1:0][TAG_W-1:0] t_q, t_n;
  logic [N-2:0]            swp;
  logic [PC_W-1:0]         pass_q;
  logic                    busy_q, done_q;
  logic                    ph;

  assign ph = pass_q[0];

  // compare-exchange decision for each adjacent pair; strict compare keeps ties in place
  for (genvar i = 0; i < N - 1; i++) begin : g_cmp
    assign swp[i] = (ph == 1'(i % 2)) && ($signed(k_q[i]) > $signed(k_q[i+1]));
  end

  for (genvar j = 0; j < N; j++) begin : g_pos
    localparam int UP = (j < N - 1) ? j + 1 : j;
    localparam int DN = (j > 0) ? j - 1 : j;
    logic from_up, from_dn;
    if (j < N - 1) begin : g_up
      assign from_up = swp[j];
    end else begin : g_noup
      assign from_up = 1'b0;
    end
    if (j > 0) begin : g_dn
      assign from_dn = swp[j-1];
    end else begin : g_nodn
      assign from_dn = 1'b0;
    end
    assign k_n[j] = from_up ? k_q[UP] : (from_dn ? k_q[DN] : k_q[j]);
    assign t_n[j] = from_up ? t_q[UP] : (from_dn ? t_q[DN] : t_q[j]);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      k_q <= keys_in;
      t_q <= tags_in;
    end else if (busy_q) begin
      k_q <= k_n;
      t_q <= t_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        pass_q <= '0;
      end else if (busy_q) begin
        pass_q <= pass_q + 1'b1;
        if (pass_q == PC_W'(N - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign keys_out = k_q;
  assign tags_out = t_q;
  assign done     = done_q;
endmodule

// File: rtl/mm_seq_ram.sv
module mm_seq_ram #(
  parameter int DEPTH = 15,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/subsrc_regroup_seq.sv
module subsrc_regroup_seq
  import mm_regroup_pkg::*;
#(
  parameter int N_MSB  = 15,
  parameter int VAL_W  = 8,
  localparam int N_SUB = 2 * N_MSB,
  localparam int IDX_W = $clog2(N_SUB),
  localparam int SEL_W = $clog2(N_MSB),
  localparam int RES_W = VAL_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_valid,
  input  logic [VAL_W-1:0] meas_value,
  input  logic [SEL_W-1:0] seq_sel,
  output logic [IDX_W-1:0] seq_sub_a,
  output logic [IDX_W-1:0] seq_sub_b,
  output logic             ready
);
  seq_state_t                     st;
  logic [N_SUB-1:0][VAL_W-1:0]    buf_q;
  logic [N_SUB-1:0][IDX_W-1:0]    idx_init;
  logic [IDX_W-1:0]               ld_cnt;
  logic [SEL_W-1:0]               wr_cnt;
  logic                           ready_q;

  logic [N_SUB-1:0][VAL_W-1:0]    s1_keys;
  logic [N_SUB-1:0][IDX_W-1:0]    s1_tags;
  logic                           s1_done;
  logic [N_MSB-1:0][RES_W-1:0]    p_keys;
  logic [N_MSB-1:0][2*IDX_W-1:0]  p_tags;
  logic [N_MSB-1:0][RES_W-1:0]    s2_keys;
  logic [N_MSB-1:0][2*IDX_W-1:0]  s2_tags;
  logic                           s2_done;

  logic                           tbl_we;
  logic [2*IDX_W-1:0]             tbl_wdata;
  logic [2*IDX_W-1:0]             tbl_rdata;

  for (genvar i = 0; i < N_SUB; i++) begin : g_idx
    assign idx_init[i] = IDX_W'(i);
  end

  mm_oet_sorter #(.N(N_SUB), .KEY_W(VAL_W), .TAG_W(IDX_W)) u_sort_val (
    .clk(clk), .rst(rst), .load(st == ST_S1LD),
    .keys_in(buf_q), .tags_in(idx_init),
    .keys_out(s1_keys), .tags_out(s1_tags), .done(s1_done)
  );

  // fold the sorted list: k-th lowest with k-th highest
  for (genvar k = 0; k < N_MSB; k++) begin : g_pair
    logic signed [RES_W-1:0] sum_k;
    assign sum_k = RES_W'($signed(s1_keys[k])) + RES_W'($signed(s1_keys[N_SUB-1-k]));
    assign p_keys[k] = sum_k[RES_W-1] ? RES_W'(-sum_k) : RES_W'(sum_k);
    assign p_tags[k] = {s1_tags[k], s1_tags[N_SUB-1-k]};
  end

  mm_oet_sorter #(.N(N_MSB), .KEY_W(RES_W), .TAG_W(2*IDX_W)) u_sort_res (
    .clk(clk), .rst(rst), .load(st == ST_S2LD),
    .keys_in(p_keys), .tags_in(p_tags),
    .keys_out(s2_keys), .tags_out(s2_tags), .done(s2_done)
  );

  assign tbl_we    = (st == ST_WR);
  assign tbl_wdata = s2_tags[wr_cnt];

  mm_seq_ram #(.DEPTH(N_MSB), .W(2*IDX_W)) u_table (
    .clk(clk), .we(tbl_we), .waddr(wr_cnt), .wdata(tbl_wdata),
    .raddr(seq_sel), .rdata(tbl_rdata)
  );

  always_ff @(posedge clk) begin
    if (st == ST_LOAD && meas_valid) buf_q[ld_cnt] <= meas_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_LOAD;
      ld_cnt  <= '0;
      wr_cnt  <= '0;
      ready_q <= 1'b0;
    end else begin
      unique case (st)
        ST_LOAD: if (meas_valid) begin
          ready_q <= 1'b0;
          if (ld_cnt == IDX_W'(N_SUB - 1)) begin
            ld_cnt <= '0;
            st     <= ST_S1LD;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        ST_S1LD:  st <= ST_S1RUN;
        ST_S1RUN: if (s1_done) st <= ST_S2LD;
        ST_S2LD:  st <= ST_S2RUN;
        ST_S2RUN: if (s2_done) begin
          st     <= ST_WR;
          wr_cnt <= '0;
        end
        ST_WR: begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == SEL_W'(N_MSB - 1)) begin
            st      <= ST_LOAD;
            ready_q <= 1'b1;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  assign seq_sub_a = tbl_rdata[2*IDX_W-1:IDX_W];
  assign seq_sub_b = tbl_rdata[IDX_W-1:0];
  assign ready     = ready_q;
endmodule

// File: rtl/subsrc_regroup_chk.sv
module subsrc_regroup_chk
  import mm_regroup_pkg::*;
#(
  parameter int N_MSB  = 15,
  parameter int VAL_W  = 8,
  localparam int N_SUB = 2 * N_MSB,
  localparam int IDX_W = $clog2(N_SUB),
  localparam int RES_W = VAL_W + 2,
  localparam int LIMIT = N_SUB + 2 * N_MSB + 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          meas_valid,
  input logic                          ready,
  input seq_state_t                    st,
  input logic [N_SUB-1:0][VAL_W-1:0]   buf_q,
  input logic [N_SUB-1:0][VAL_W-1:0]   s1_keys,
  input logic [N_SUB-1:0][IDX_W-1:0]   s1_tags,
  input logic                          s1_done,
  input logic [N_MSB-1:0][RES_W-1:0]   s2_keys,
  input logic                          s2_done,
  input logic                          tbl_we,
  input logic [2*IDX_W-1:0]            tbl_wdata
);
  logic [N_SUB-1:0] seen;
  logic [7:0]       busy_cyc;

  always_comb begin
    seen = '0;
    for (int i = 0; i < N_SUB; i++) seen[s1_tags[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || st == ST_LOAD) busy_cyc <= '0;
    else                      busy_cyc <= busy_cyc + 1'b1;
  end

  a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (ready && meas_valid) |=> !ready);

  a_r8_no_write_while_ready: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> !ready);

  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (st != ST_LOAD) |=> $stable(buf_q));

  a_r3_perm: assert property (@(posedge clk) disable iff (rst)
    s1_done |-> (&seen));

  a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> (tbl_wdata[2*IDX_W-1:IDX_W] < IDX_W'(N_SUB)) && (tbl_wdata[IDX_W-1:0] < IDX_W'(N_SUB)));

  a_r10_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_cyc <= 8'(LIMIT));

  for (genvar i = 0; i < N_SUB - 1; i++) begin : g_s1
    a_r3_sorted: assert property (@(posedge clk) disable iff (rst)
      s1_done |-> ($signed(s1_keys[i]) <= $signed(s1_keys[i+1])));
    a_r3_stable: assert property (@(posedge clk) disable iff (rst)
      (s1_done && s1_keys[i] == s1_keys[i+1]) |-> (s1_tags[i] < s1_tags[i+1]));
  end

  for (genvar k = 0; k < N_MSB - 1; k++) begin : g_s2
    a_r5_res_order: assert property (@(posedge clk) disable iff (rst)
      s2_done |-> (s2_keys[k] <= s2_keys[k+1]));
  end
endmodule

bind subsrc_regroup_seq subsrc_regroup_chk #(.N_MSB(N_MSB), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst(rst), .meas_valid(meas_valid), .ready(ready), .st(st),
  .buf_q(buf_q), .s1_keys(s1_keys), .s1_tags(s1_tags), .s1_done(s1_done),
  .s2_keys(s2_keys), .s2_done(s2_done), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata)
);

// File: tb/subsrc_regroup_seq_bench.sv
`timescale 1ns/1ps
module subsrc_regroup_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       meas_valid = 1'b0;
  logic [7:0] meas_value = '0;
  logic [3:0] seq_sel = '0;
  logic [4:0] seq_sub_a, seq_sub_b;
  logic       ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int vals[30];
  int ord[30];
  int pa[15], pb[15], pr[15];
  int exp_a[15], exp_b[15];
  int old_a[15], old_b[15];

  localparam int NPAT = 6;
  localparam int PAT_ID [NPAT]   = '{0, 1, 2, 3, 4, 5};
  localparam bit PAT_JUNK [NPAT] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  always #2.5 clk = ~clk;

  subsrc_regroup_seq u_subsrc_regroup_seq (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_value(meas_value),
    .seq_sel(seq_sel), .seq_sub_a(seq_sub_a), .seq_sub_b(seq_sub_b), .ready(ready)
  );

  function automatic int gen(input int p, input int i);
    case (p)
      0:       return i * 8 - 120;
      1:       return 100 - i * 7;
      2:       return 5;
      3:       return ((i * 37 + 13) * (i + 5)) % 256 - 128;
      4:       return (i % 2 == 0) ? -128 : 127;
      default: return (i * i * 11 + 7 * i + 3) % 256 - 128;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference order: stable ascending sort, fold, stable sort by |residual|
  task automatic build(input int p);
    for (int i = 0; i < 30; i++) begin vals[i] = gen(p, i); ord[i] = i; end
    for (int i = 1; i < 30; i++) begin
      int j = i;
      while (j > 0 && vals[ord[j-1]] > vals[ord[j]]) begin
        int t = ord[j]; ord[j] = ord[j-1]; ord[j-1] = t; j--;
      end
    end
    for (int k = 0; k < 15; k++) begin
      int s;
      pa[k] = ord[k]; pb[k] = ord[29-k];
      s = vals[pa[k]] + vals[pb[k]];
      pr[k] = (s < 0) ? -s : s;
    end
    for (int i = 1; i < 15; i++) begin
      int j = i;
      while (j > 0 && pr[j-1] > pr[j]) begin
        int t;
        t = pr[j]; pr[j] = pr[j-1]; pr[j-1] = t;
        t = pa[j]; pa[j] = pa[j-1]; pa[j-1] = t;
        t = pb[j]; pb[j] = pb[j-1]; pb[j-1] = t;
        j--;
      end
    end
    for (int k = 0; k < 15; k++) begin exp_a[k] = pa[k]; exp_b[k] = pb[k]; end
  endtask

  task automatic send(input int p, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      meas_valid = 1'b1;
      meas_value = 8'(gen(p, i));
    end
  endtask

  task automatic wait_ready(input bit junk, output int n);
    @(negedge clk);
    n = 0;
    meas_valid = junk;
    meas_value = 8'h55;
    while (!ready && n < 200) begin
      @(negedge clk);
      n++;
      if (n >= 20) meas_valid = 1'b0;
    end
    meas_valid = 1'b0;
  endtask

  task automatic check_table(input bit use_old, input string req);
    for (int e = 0; e < 15; e++) begin
      int ea, eb;
      ea = use_old ? old_a[e] : exp_a[e];
      eb = use_old ? old_b[e] : exp_b[e];
      @(negedge clk);
      seq_sel = 4'(e);
      @(negedge clk);
      chk(int'(seq_sub_a) == ea, req, int'(seq_sub_a), ea);
      chk(int'(seq_sub_b) == eb, req, int'(seq_sub_b), eb);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", int'(ready), 0);

    // vector table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NPAT; v++) begin
      build(PAT_ID[v]);
      send(PAT_ID[v], 0, 30);
      wait_ready(PAT_JUNK[v], n);
      chk(n <= 64, "R10 latency", n, 64);
      chk(ready == 1'b1, "R7 ready raised", int'(ready), 1);
      check_table(1'b0, PAT_JUNK[v] ? "R9 R3 R4 R5 R6 table with junk strobes"
                                    : "R2 R3 R4 R5 R6 table");
    end

    // split load: old table must stay visible (R8), ready must drop (R7)
    for (int k = 0; k < 15; k++) begin old_a[k] = exp_a[k]; old_b[k] = exp_b[k]; end
    build(0);
    send(0, 0, 4);
    @(negedge clk);
    meas_valid = 1'b0;
    chk(ready == 1'b0, "R7 ready cleared by new load", int'(ready), 0);
    check_table(1'b1, "R8 old table during load");
    send(0, 4, 30);
    @(negedge clk);
    meas_valid = 1'b0;
    seq_sel = 4'd0;
    @(negedge clk);
    chk(int'(seq_sub_a) == old_a[0], "R8 old table during processing", int'(seq_sub_a), old_a[0]);
    chk(ready == 1'b0, "R7 ready low while processing", int'(ready), 0);
    n = 0;
    while (!ready && n < 200) begin @(negedge clk); n++; end
    chk(ready == 1'b1, "R7 ready after split load", int'(ready), 1);
    check_table(1'b0, "R2 R3 R4 R5 R6 table after split load");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule